// File: doc/BRIEF.md
# MDIO Management Register Engine

This block is a clause-22 management master for an Ethernet PHY, operated through two 16-bit registers. The control register holds a PHY address, a register address and two command bits. The data register holds the value for a write, or receives the value from a read. Software writes the control word with one command bit set. The engine then runs one full management frame on the MDC clock and the MDIO data line. When the frame ends, the engine clears the command bit. Software polls that bit to detect completion.

Both registers are read back at all times on dedicated outputs. Register writes use a plain strobe with a select line and have no back-pressure: a write that arrives while a frame is running is dropped. The MDIO pad is modelled as an output value, an output enable and an input. The enable low means the line is released to high impedance. MDC comes from a divider of the system clock. With the default half-period of 10 cycles on a 50 MHz clock, MDC runs at 2.5 MHz.

Top module: `mdio_reg_engine`

## Requirements
- R1: Control word layout: bit 0 is the read command, bit 1 is the write command, bits 8:4 are the register address, and bits 13:9 are the PHY address. Bits 15:14 and 3:2 read back as zero. A control write with neither command bit set only stores the two addresses and starts no frame.
- R2: A command bit reads back as 1 from the clock edge that accepts it until the frame ends. It clears on the clock edge of the last MDC falling edge, which is 128 × HALF_DIV cycles after acceptance.
- R3: Every frame sends, most significant bit first, in this order: 32 ones, the start pattern 01, the opcode (10 for a read, 01 for a write), the 5-bit PHY address and the 5-bit register address.
- R4: In a write frame, the turnaround bits are driven as 10. They are followed by the 16 bits of the data register, MSB first. The data register keeps its value.
- R5: In a read frame, MDIO is released from the turnaround (bit 46) to the end of the frame. The 16 bits present at the rising MDC edges of bits 48 to 63 are loaded MSB first into the data register when the frame ends.
- R6: MDC stays low while idle. Once a frame starts, each MDC half period lasts HALF_DIV clock cycles, beginning with a low half. MDIO output changes only on MDC falling edges or at frame start.
- R7: A control write with both command bits set runs a read only, and reads back with bit 0 set and bit 1 clear.
- R8: Writes to either register while a frame is running are ignored. The read-back values do not change.
- R9: While idle, the MDIO output enable is low and the MDIO output value is 0.
- R10: After reset, both registers read 0, MDC is low and MDIO is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_sel | input | 1 | 0 selects the control register, 1 selects the data register |
| reg_wr_data | input | 16 | Register write value |
| ctrl_rdata | output | 16 | Control register read-back |
| data_rdata | output | 16 | Data register read-back |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable; low releases the line |
| mdio_i | input | 1 | MDIO input value |

## Verification
A wrong bit counter or shift register appears on mdio_o or mdio_oe in the same MDC bit period where it goes wrong, because the line is compared against the expected frame on every system clock. A divider fault appears on mdc within one half period. A fault in the command, busy or register-hold logic appears on the read-back ports on the next cycle. A wrong sampling edge in a read appears only in data_rdata, on the cycle the frame completes.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int CTRL_W  = 16;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int RD_BIT  = 0;
  localparam int WR_BIT  = 1;
  localparam int REG_LSB = 4;
  localparam int PHY_LSB = 9;
  // Bits after the preamble: start 2, opcode 2, two addresses, turnaround 2, data.
  localparam int BODY_W  = 2 + 2 + 2 * ADDR_W + 2 + DATA_W;

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regad;
  } mdio_addr_t;
endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          toggle;

  assign toggle   = run && (cnt == CNT_LAST);
  assign rise_stb = toggle && !mdc;
  assign fall_stb = toggle && mdc;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (toggle) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R6: the clock parks low whenever no frame runs.
  p_mdc_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
  // R6: a falling strobe only ever comes from a high clock.
  p_fall_from_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fall_stb |=> !mdc);
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
  parameter int FRAME_LEN = 64,
  parameter int DATA_W    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_rd,
  input  logic [FRAME_LEN-1:0] frame,
  input  logic                 rise_stb,
  input  logic                 fall_stb,
  input  logic                 mdio_i,
  output logic                 active,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done,
  output logic [DATA_W-1:0]    rd_data
);
  localparam int IW       = $clog2(FRAME_LEN);
  localparam int DATA_POS = FRAME_LEN - DATA_W;
  localparam int TA_POS   = DATA_POS - 2;
  localparam logic [IW-1:0] IDX_LAST = IW'(FRAME_LEN - 1);
  localparam logic [IW:0]   TA_IDX   = (IW+1)'(TA_POS);
  localparam logic [IW:0]   DATA_IDX = (IW+1)'(DATA_POS);

  logic [IW-1:0]      idx;
  logic [IW:0]        idx_next;
  logic [FRAME_LEN-1:0] shreg;
  logic               is_rd;
  logic               oe_q;

  assign idx_next = {1'b0, idx} + (IW+1)'(1);
  assign done     = active && fall_stb && (idx == IDX_LAST);
  assign mdio_oe  = oe_q;
  assign mdio_o   = shreg[FRAME_LEN-1] & oe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      idx     <= '0;
      shreg   <= '0;
      is_rd   <= 1'b0;
      oe_q    <= 1'b0;
      rd_data <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
      shreg  <= frame;
      is_rd  <= start_rd;
      oe_q   <= 1'b1;
    end else if (active) begin
      if (rise_stb && is_rd && ({1'b0, idx} >= DATA_IDX))
        rd_data <= {rd_data[DATA_W-2:0], mdio_i};
      if (done) begin
        active <= 1'b0;
        oe_q   <= 1'b0;
      end else if (fall_stb) begin
        idx   <= idx_next[IW-1:0];
        shreg <= {shreg[FRAME_LEN-2:0], 1'b0};
        oe_q  <= !(is_rd && (idx_next >= TA_IDX));
      end
    end
  end

  // R9: the line is released whenever the sequencer is idle.
  p_released_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !mdio_oe);
  // R6: while driving, the output value moves only on a falling strobe.
  p_change_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$past(fall_stb)) |-> $stable(mdio_o));
  // R5: a read never drives from the turnaround onward.
  p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && is_rd && ({1'b0, idx} >= TA_IDX)) |-> !mdio_oe);
  // R8: the register stage never restarts a running frame.
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !start);
endmodule

// File: rtl/mdio_reg_engine.sv
module mdio_reg_engine #(
  parameter int HALF_DIV = 10,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic        reg_wr_sel,
  input  logic [15:0] reg_wr_data,
  output logic [15:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  localparam int FRAME_LEN = PRE_LEN + BODY_W;

  mdio_addr_t          addr_q;
  mdio_addr_t          addr_in;
  logic                rd_pend;
  logic                wr_pend;
  logic [DATA_W-1:0]   data_q;
  logic                ctrl_acc;
  logic                start;
  logic                start_rd;
  logic [FRAME_LEN-1:0] frame;
  logic                active;
  logic                done;
  logic                rise_stb;
  logic                fall_stb;
  logic [DATA_W-1:0]   rd_data;

  assign addr_in.phy   = reg_wr_data[PHY_LSB +: ADDR_W];
  assign addr_in.regad = reg_wr_data[REG_LSB +: ADDR_W];
  assign ctrl_acc = reg_wr_en && !reg_wr_sel && !active;
  assign start    = ctrl_acc && (reg_wr_data[RD_BIT] || reg_wr_data[WR_BIT]);
  assign start_rd = reg_wr_data[RD_BIT];

  assign frame = {{PRE_LEN{1'b1}}, 2'b01,
                  start_rd ? 2'b10 : 2'b01,
                  addr_in.phy, addr_in.regad,
                  start_rd ? 2'b11 : 2'b10,
                  start_rd ? {DATA_W{1'b1}} : data_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_pend <= 1'b0;
      wr_pend <= 1'b0;
      data_q  <= '0;
    end else begin
      if (ctrl_acc) begin
        addr_q  <= addr_in;
        rd_pend <= reg_wr_data[RD_BIT];
        wr_pend <= reg_wr_data[WR_BIT] && !reg_wr_data[RD_BIT];
      end else if (done) begin
        rd_pend <= 1'b0;
        wr_pend <= 1'b0;
      end
      if (done && rd_pend)
        data_q <= rd_data;
      else if (reg_wr_en && reg_wr_sel && !active)
        data_q <= reg_wr_data;
    end
  end

  assign ctrl_rdata = {2'b00, addr_q.phy, addr_q.regad, 2'b00, wr_pend, rd_pend};
  assign data_rdata = data_q;

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .run(active),
    .mdc(mdc), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  mdio_frame_seq #(.FRAME_LEN(FRAME_LEN), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_rd(start_rd),
    .frame(frame), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .mdio_i(mdio_i), .active(active), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .rd_data(rd_data)
  );

  // R7: at most one command is ever pending.
  p_one_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_pend && wr_pend));
  // R2: the end of a frame leaves both command bits clear.
  p_done_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (ctrl_rdata[1:0] == 2'b00));
  // R2: a command bit is pending exactly while the frame runs.
  p_busy_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    active == (rd_pend || wr_pend));
  // R8: addresses stay frozen for the whole frame.
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && $past(active)) |-> $stable(addr_q));
endmodule

// File: tb/sim_mdio_reg_engine.sv
module sim_mdio_reg_engine;
  localparam int H    = 3;
  localparam int FCYC = 128 * H;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic        mdio_i = 1'b1;
  logic [15:0] ctrl_q, data_q;
  logic        mdc, mdio_o, mdio_oe;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  logic [15:0] model_data = '0;

  always #10 clk = ~clk;

  mdio_reg_engine #(.HALF_DIV(H), .PRE_LEN(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(wr_en), .reg_wr_sel(wr_sel),
    .reg_wr_data(wr_data), .ctrl_rdata(ctrl_q), .data_rdata(data_q),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Returns at the negedge right after the accepting clock edge.
  task automatic reg_write(input bit sel, input logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [15:0] cword(input logic [4:0] phy, input logic [4:0] rg,
                                        input logic [1:0] cmd);
    return {2'b00, phy, rg, 2'b00, cmd};
  endfunction

  task automatic run_frame(input logic [15:0] cw, input logic [15:0] phyval, input bit inject);
    bit rd, wr;
    logic [63:0] f;
    logic [15:0] cexp;
    rd = cw[0];
    wr = cw[1] & ~cw[0];
    // R3 order: 32 ones, 01, opcode, phy, reg; R4 turnaround 10 then data.
    f = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), cw[13:9], cw[8:4], 2'b10, model_data};
    cexp = {2'b00, cw[13:9], cw[8:4], 2'b00, wr, rd};
    reg_write(1'b0, cw);
    chk("R7 command bits after accept", {30'd0, ctrl_q[1:0]}, {30'd0, wr, rd});
    for (int k = 0; k < FCYC; k++) begin
      int b;
      bit oe_e;
      b = k / (2 * H);
      oe_e = !(rd && b >= 46);
      if (b >= 48) mdio_i = phyval[63 - b];
      else mdio_i = 1'b1;
      chk("R6 mdc period", {31'd0, mdc}, ((k / H) % 2));
      chk(rd ? "R5 read release" : "R4 write drive", {31'd0, mdio_oe}, {31'd0, oe_e});
      chk(b < 34 ? "R3 preamble/start" : (b < 46 ? "R3 opcode/address" : "R4 turnaround/data"),
          {31'd0, mdio_o}, {31'd0, oe_e ? f[63 - b] : 1'b0});
      chk("R2 command held busy", {16'd0, ctrl_q}, {16'd0, cexp});
      chk("R8 data hold while busy", {16'd0, data_q}, {16'd0, model_data});
      if (inject && k == 20) begin
        wr_en = 1'b1; wr_sel = 1'b0; wr_data = 16'h3FF2;
      end else if (inject && k == 21) begin
        wr_sel = 1'b1; wr_data = 16'hDEAD;
      end else if (inject && k == 22) begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    if (rd) model_data = phyval;
    chk("R2 command cleared", {16'd0, ctrl_q}, {16'd0, cexp & 16'hFFFC});
    chk(rd ? "R5 data loaded" : "R4 data kept", {16'd0, data_q}, {16'd0, model_data});
    chk("R9 released at end", {30'd0, mdio_oe, mdio_o}, 32'd0);
    chk("R6 mdc low at end", {31'd0, mdc}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset values
    chk("R10 ctrl reset", {16'd0, ctrl_q}, 32'd0);
    chk("R10 data reset", {16'd0, data_q}, 32'd0);
    chk("R10 mdc/mdio reset", {29'd0, mdc, mdio_oe, mdio_o}, 32'd0);
    rst_n = 1'b1;

    reg_write(1'b1, 16'hA5C3);
    model_data = 16'hA5C3;
    chk("R4 data register write", {16'd0, data_q}, {16'd0, model_data});

    run_frame(cword(5'h11, 5'h03, 2'b10), 16'h0000, 1'b1);
    run_frame(cword(5'h1F, 5'h00, 2'b01), 16'h1234, 1'b1);
    run_frame(cword(5'h02, 5'h1A, 2'b11), 16'hBEEF, 1'b0);

    // R1: address-only write with stray bits in 15:14 and 3:2 starts nothing.
    reg_write(1'b0, 16'hC00C | cword(5'h0A, 5'h15, 2'b00));
    chk("R1 address-only readback", {16'd0, ctrl_q}, {16'd0, cword(5'h0A, 5'h15, 2'b00)});
    for (int k = 0; k < 8 * H; k++) begin
      chk("R9 idle after address write", {30'd0, mdio_oe, mdc}, 32'd0);
      @(negedge clk);
    end

    reg_write(1'b1, 16'hFFFF);
    model_data = 16'hFFFF;
    run_frame(cword(5'h00, 5'h1F, 2'b10), 16'h0000, 1'b0);
    run_frame(cword(5'h15, 5'h0A, 2'b01), 16'h0001, 1'b0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule